// File: doc/BRIEF.md
# Host Sampling and Serial Readout Sequencer

This block runs periodic conversions on one or more serial slave converters that share a chip-select and form a daisy chain. A free-running timer decides when each sample is due. On that tick the block pulses a convert-start output and then waits for the converters' busy line to go from high to low. Only after busy has fallen does it pull chip-select low and produce a burst of serial clocks. The clock idles low, the slave launches each bit on the rising edge, and the block captures it on the falling edge. It collects sixteen bits per chained device, most significant bit first, and hands each finished word out on a one-cycle valid strobe.

The sample period, the serial clock divider and the number of chained devices are configuration inputs. The divider lets the host keep the serial rate within the slave's limit, which is roughly 17 Mb/s. All words of a chain are read inside one chip-select frame. The word from the device nearest the host arrives first. A timer tick that lands while a conversion or a readout is still in progress is not acted upon. It is reported on an overrun strobe instead.

Top module: `spi_sample_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, csN is 1 and sclk, cnvStart, wordValid and overrun are 0.
- R2: A timer tick is taken when the internal period count reaches cfgPeriod. With the block idle, consecutive cnvStart pulses are exactly cfgPeriod+1 cycles apart, and each pulse lasts one cycle.
- R3: csN stays 1 while busyIn is high. csN goes to 0 at the first clock edge that sees busyIn low after it was high.
- R4: sclk is 0 whenever csN is 1. Within a frame, each high phase and each low phase of sclk lasts cfgDiv+1 cycles. The first rising edge comes cfgDiv+1 cycles after csN falls.
- R5: sdi is captured at each falling edge of sclk. Each word is assembled with the first captured bit as bit 15. wordValid is a one-cycle pulse on the cycle after the sixteenth capture of that word.
- R6: A frame holds 16 × D rising sclk edges and yields D words, where D is the effective device count. Words come out in arrival order, so the device nearest the host comes first. wordLast is 1 only together with the final word of the frame.
- R7: cfgDevices is sampled on the timer tick that starts a frame. A value of 0 is treated as 1, and a value above MAX_DEV is treated as MAX_DEV.
- R8: A timer tick that arrives while a conversion or a readout is in progress produces a one-cycle overrun pulse and no cnvStart. The frame in progress finishes unchanged.
- R9: No sclk activity occurs while busyIn is high.
- R10: At the falling sclk edge that captures the last bit, csN returns to 1 and sclk is left at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPeriod | input | PERIOD_W | Sample period minus one, in clock cycles |
| cfgDiv | input | DIV_W | Serial clock half period minus one, in clock cycles |
| cfgDevices | input | CFG_DEV_W | Number of converters in the chain |
| busyIn | input | 1 | Conversion-in-progress flag from the converters |
| sdi | input | 1 | Serial data from the nearest converter |
| cnvStart | output | 1 | One-cycle conversion request |
| csN | output | 1 | Active-low chip-select for the chain |
| sclk | output | 1 | Serial clock, idle low |
| wordValid | output | 1 | One-cycle strobe for a finished word |
| wordData | output | 16 | Received word |
| wordLast | output | 1 | Marks the final word of a frame |
| overrun | output | 1 | One-cycle strobe for a dropped timer tick |

## Verification
The sample timer runs on its own, so a tick can land in the same cycle as a serial capture or a word emission of a frame that is still in progress. The bench provokes this by setting the period well below the length of a two-device frame at a slow divider. It then counts the overrun pulses and checks that cnvStart never rises while chip-select is low. It also checks that every word and every clock edge of that frame still match the values expected from the chain model.

// File: rtl/spi_sample_pkg.sv
package spi_sample_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } seqState_t;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic sample;  // capture sdi this cycle
    logic emit;    // this capture completes a word
    logic last;    // this word closes the frame
  } dpCtl_t;

endpackage

// File: rtl/spi_sample_dp.sv
module spi_sample_dp
  import spi_sample_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  dpCtl_t            dpCtl,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  output logic              wordLast
);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] shiftNext;

  assign shiftNext = {shiftReg[WORD_W-2:0], sdi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (dpCtl.sample) begin
      shiftReg <= shiftNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      wordData  <= '0;
      wordLast  <= 1'b0;
    end else begin
      wordValid <= dpCtl.sample && dpCtl.emit;
      if (dpCtl.sample && dpCtl.emit) begin
        wordData <= shiftNext;
        wordLast <= dpCtl.last;
      end
    end
  end

endmodule

// File: rtl/spi_sample_ctrl_seq.sv
module spi_sample_ctrl_seq
  import spi_sample_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_DEV   = 4,
  parameter int PERIOD_W  = 16,
  parameter int DIV_W     = 8,
  parameter int CFG_DEV_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PERIOD_W-1:0]  cfgPeriod,
  input  logic [DIV_W-1:0]     cfgDiv,
  input  logic [CFG_DEV_W-1:0] cfgDevices,
  input  logic                 busyIn,
  output logic                 cnvStart,
  output logic                 csN,
  output logic                 sclk,
  output logic                 overrun,
  output dpCtl_t               dpCtl
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam int DEV_W = $clog2(MAX_DEV + 1);

  seqState_t            state;
  logic [PERIOD_W-1:0]  periodCnt;
  logic [DIV_W-1:0]     halfCnt;
  logic [BIT_W-1:0]     bitIdx;
  logic [DEV_W-1:0]     wordIdx;
  logic [DEV_W-1:0]     devCount;
  logic [DEV_W-1:0]     devEff;
  logic                 busyQ;
  logic                 tick;
  logic                 busyFall;
  logic                 halfDone;
  logic                 fallNow;
  logic                 wordEnd;
  logic                 frameEnd;

  assign tick     = periodCnt >= cfgPeriod;
  assign busyFall = busyQ && !busyIn;
  assign halfDone = halfCnt >= cfgDiv;
  assign fallNow  = (state == ST_READ) && halfDone && sclk;
  assign wordEnd  = bitIdx == BIT_W'(WORD_W - 1);
  assign frameEnd = fallNow && wordEnd && (wordIdx == devCount - DEV_W'(1));

  always_comb begin
    if (cfgDevices == '0) begin
      devEff = DEV_W'(1);
    end else if (cfgDevices > CFG_DEV_W'(MAX_DEV)) begin
      devEff = DEV_W'(MAX_DEV);
    end else begin
      devEff = DEV_W'(cfgDevices);
    end
  end

  always_comb begin
    dpCtl.sample = fallNow;
    dpCtl.emit   = fallNow && wordEnd;
    dpCtl.last   = frameEnd;
  end

  // free-running sample timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
      busyQ     <= 1'b0;
      cnvStart  <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      periodCnt <= tick ? '0 : periodCnt + 1'b1;
      busyQ     <= busyIn;
      cnvStart  <= tick && (state == ST_IDLE);
      overrun   <= tick && (state != ST_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      halfCnt  <= '0;
      bitIdx   <= '0;
      wordIdx  <= '0;
      devCount <= DEV_W'(1);
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (tick) begin
            devCount <= devEff;
            state    <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (busyFall) begin
            state   <= ST_READ;
            csN     <= 1'b0;
            sclk    <= 1'b0;
            halfCnt <= '0;
            bitIdx  <= '0;
            wordIdx <= '0;
          end
        end
        ST_READ: begin
          if (halfDone) begin
            halfCnt <= '0;
            sclk    <= !sclk;
            if (sclk) begin
              bitIdx <= wordEnd ? '0 : bitIdx + 1'b1;
              if (wordEnd) begin
                wordIdx <= wordIdx + 1'b1;
              end
              if (frameEnd) begin
                state <= ST_IDLE;
                csN   <= 1'b1;
              end
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_sample_ctrl.sv
module spi_sample_ctrl
  import spi_sample_pkg::*;
#(
  parameter int MAX_DEV   = 4,
  parameter int PERIOD_W  = 16,
  parameter int DIV_W     = 8,
  parameter int CFG_DEV_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PERIOD_W-1:0]  cfgPeriod,
  input  logic [DIV_W-1:0]     cfgDiv,
  input  logic [CFG_DEV_W-1:0] cfgDevices,
  input  logic                 busyIn,
  input  logic                 sdi,
  output logic                 cnvStart,
  output logic                 csN,
  output logic                 sclk,
  output logic                 wordValid,
  output logic [15:0]          wordData,
  output logic                 wordLast,
  output logic                 overrun
);

  localparam int WORD_W = 16;

  dpCtl_t dpCtl;

  spi_sample_ctrl_seq #(
    .WORD_W   (WORD_W),
    .MAX_DEV  (MAX_DEV),
    .PERIOD_W (PERIOD_W),
    .DIV_W    (DIV_W),
    .CFG_DEV_W(CFG_DEV_W)
  ) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .cfgPeriod (cfgPeriod),
    .cfgDiv    (cfgDiv),
    .cfgDevices(cfgDevices),
    .busyIn    (busyIn),
    .cnvStart  (cnvStart),
    .csN       (csN),
    .sclk      (sclk),
    .overrun   (overrun),
    .dpCtl     (dpCtl)
  );

  spi_sample_dp #(
    .WORD_W(WORD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sdi      (sdi),
    .dpCtl    (dpCtl),
    .wordValid(wordValid),
    .wordData (wordData),
    .wordLast (wordLast)
  );

endmodule

// File: rtl/spi_sample_ctrl_chk.sv
module spi_sample_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic busyIn,
  input logic cnvStart,
  input logic csN,
  input logic sclk,
  input logic wordValid,
  input logic overrun
);

  assert_cnv_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    cnvStart |=> !cnvStart);

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  assert_word_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  assert_no_cnv_in_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !cnvStart);

  assert_overrun_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> !cnvStart);

  assert_quiet_conv_R9: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |-> (csN && !sclk));

endmodule

bind spi_sample_ctrl spi_sample_ctrl_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busyIn   (busyIn),
  .cnvStart (cnvStart),
  .csN      (csN),
  .sclk     (sclk),
  .wordValid(wordValid),
  .overrun  (overrun)
);

// File: tb/spi_sample_ctrl_tb.sv
module spi_sample_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_DEV    = 4;
  localparam int CHAIN_W    = MAX_DEV * 16;

  typedef struct packed {
    logic [15:0] period;
    logic [7:0]  div;
    logic [3:0]  devs;
    logic [15:0] seed;
    logic [7:0]  busyLen;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{16'd600, 8'd0, 4'd1, 16'hA5C3, 8'd6},
    '{16'd600, 8'd1, 4'd2, 16'h8001, 8'd3},
    '{16'd900, 8'd3, 4'd4, 16'hFFFF, 8'd12},
    '{16'd600, 8'd2, 4'd0, 16'h0001, 8'd1},
    '{16'd900, 8'd0, 4'd7, 16'h7E11, 8'd20}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cfgPeriod = '0;
  logic [7:0]  cfgDiv = '0;
  logic [3:0]  cfgDevices = 4'd1;
  logic        busyIn = 1'b0;
  logic        sdi = 1'b0;
  logic        cnvStart, csN, sclk, wordValid, wordLast, overrun;
  logic [15:0] wordData;

  int          nChecks = 0;
  int          nFail = 0;
  longint      cyc = 0;
  logic [CHAIN_W-1:0] chainLoad = '0;
  logic [CHAIN_W-1:0] chain = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_sample_ctrl #(.MAX_DEV(MAX_DEV)) u_dut (
    .clk(clk), .rstN(rstN), .cfgPeriod(cfgPeriod), .cfgDiv(cfgDiv),
    .cfgDevices(cfgDevices), .busyIn(busyIn), .sdi(sdi),
    .cnvStart(cnvStart), .csN(csN), .sclk(sclk), .wordValid(wordValid),
    .wordData(wordData), .wordLast(wordLast), .overrun(overrun)
  );

  // daisy-chain slave model: loads on select, launches a bit on each rising sclk
  always @(negedge csN or posedge sclk) begin
    if (sclk) begin
      sdi   <= chain[CHAIN_W-1];
      chain <= chain << 1;
    end else begin
      chain <= chainLoad;
    end
  end

  function automatic logic [15:0] devWord(input logic [15:0] seed, input int i);
    return seed + 16'(i * 15473);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runFrame(input vec_t v, output int ovr, output longint tStart);
    int eff, rises, hiLen, nWords, cnvIn, guard;
    bit badHi, csBad, done;
    logic prevS;
    eff = (v.devs == 0) ? 1 : ((v.devs > MAX_DEV) ? MAX_DEV : int'(v.devs));
    for (int i = 0; i < MAX_DEV; i++) chainLoad[(MAX_DEV-1-i)*16 +: 16] = devWord(v.seed, i);
    ovr = 0; guard = 0; rises = 0; hiLen = 0; nWords = 0; cnvIn = 0;
    badHi = 0; csBad = 0; done = 0; prevS = 0;
    while (!cnvStart && guard < 5000) begin
      @(negedge clk);
      if (overrun) ovr++;
      guard++;
    end
    chk(cnvStart, "R2 convert request issued", cnvStart, 1);
    tStart = cyc;
    busyIn = 1'b1;
    for (int i = 0; i < int'(v.busyLen); i++) begin
      @(negedge clk);
      if (overrun) ovr++;
      if (!csN || sclk) csBad = 1;
    end
    chk(!csBad, "R3/R9 bus quiet while busy", csBad, 0);
    busyIn = 1'b0;
    @(negedge clk);
    chk(!csN, "R3 select after busy fall", csN, 0);
    guard = 0;
    while (!done && guard < 20000) begin
      if (overrun) ovr++;
      if (cnvStart) cnvIn++;
      if (sclk && !prevS) rises++;
      if (sclk) hiLen++;
      if (!sclk && prevS) begin
        if (hiLen != int'(v.div) + 1) badHi = 1;
        hiLen = 0;
      end
      prevS = sclk;
      if (wordValid) begin
        chk(wordData == devWord(v.seed, nWords), "R5 R6 word value and order",
            wordData, devWord(v.seed, nWords));
        chk(wordLast == (nWords == eff - 1), "R6 last-word flag", wordLast, nWords == eff - 1);
        nWords++;
        if (wordLast) done = 1;
      end
      if (!done) begin
        @(negedge clk);
        guard++;
      end
    end
    chk(done, "R6 frame completed", done, 1);
    chk(rises == eff * 16, "R4 R7 rising edges per frame", rises, eff * 16);
    chk(!badHi, "R4 high phase length", badHi, 0);
    chk(nWords == eff, "R6 R7 words per frame", nWords, eff);
    chk(cnvIn == 0, "R8 no request inside frame", cnvIn, 0);
    chk(csN && !sclk, "R10 select released, clock low", {csN, sclk}, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int ovr;
    longint t1, t2;
    bit rstBad;
    rstBad = 0;
    // R1: reset state, period 0 would tick every cycle if not held in reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!csN || sclk || cnvStart || wordValid || overrun) rstBad = 1;
    end
    chk(!rstBad, "R1 outputs held during reset", rstBad, 0);
    cfgPeriod = 16'd600;
    rstN = 1'b1;
    @(negedge clk);
    chk(csN, "R1 csN after reset", csN, 1);
    chk(!sclk, "R1 sclk after reset", sclk, 0);
    chk(!cnvStart && !wordValid && !overrun, "R1 strobes after reset",
        {cnvStart, wordValid, overrun}, 0);

    // table-driven frames
    for (int k = 0; k < NVEC; k++) begin
      cfgPeriod  = VECS[k].period;
      cfgDiv     = VECS[k].div;
      cfgDevices = VECS[k].devs;
      runFrame(VECS[k], ovr, t1);
      chk(ovr == 0, "R8 no overrun with long period", ovr, 0);
    end

    // R2: spacing of consecutive requests
    cfgPeriod = 16'd300; cfgDiv = 8'd0; cfgDevices = 4'd1;
    runFrame('{16'd300, 8'd0, 4'd1, 16'h1234, 8'd4}, ovr, t1);
    runFrame('{16'd300, 8'd0, 4'd1, 16'h4321, 8'd4}, ovr, t2);
    chk(t2 - t1 == 301, "R2 request spacing", t2 - t1, 301);

    // R8: ticks during a long frame are dropped and flagged
    cfgPeriod = 16'd40; cfgDiv = 8'd3; cfgDevices = 4'd2;
    runFrame('{16'd40, 8'd3, 4'd2, 16'hC0DE, 8'd8}, ovr, t1);
    chk(ovr > 0, "R8 overrun reported", ovr, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule